// File: doc/BRIEF.md
# Multiple-register transfer address sequencer

This block turns one block load/store instruction word into a series of single-word memory transfers. For each register named in the 16-bit mask it issues one transfer. Each transfer carries the register index, the word address and the direction. The block also carries a flag that asks for a status load or forces access to the user register bank. When the series ends, the block reports the value that the base register should take on write-back.

A pipeline front end pulses `start` with the instruction word, the current base register value, the instruction's own address and the result of the condition test. The block then holds `xfer_valid` and steps once for every cycle in which the memory side raises `xfer_rdy`. Registers always go out in ascending index order. The lowest-numbered register always lands at the lowest address. The addressing follows all four stack disciplines: offset before or after the transfer, combined with ascending or descending memory. When a store includes the program counter, the block supplies the instruction address plus 12 as that word's data.

Top module: `blk_xfer_seq`

## Requirements
- R1: A `start` pulse is taken only while `busy` is low and only when instr[27:25] equals 3'b100. Any other opcode produces no transfer and no `done`. The decoded fields are: 24 = pre-offset, 23 = ascending, 22 = user/status flag, 21 = write-back, 20 = load, 19:16 = base register index, 15:0 = register mask.
- R2: For every set mask bit i, exactly one transfer is issued with `xfer_reg` = i. Transfers go out in strictly ascending index order.
- R3: Addresses step by +4 from the lowest address. With n set bits and base B, the first address is: ascending/post → B; ascending/pre → B+4; descending/post → B−4n+4; descending/pre → B−4n.
- R4: `xfer_load` equals instr bit 20 and `xfer_user` equals instr bit 22 for every transfer of the instruction.
- R5: A transfer is accepted on a clock edge where `xfer_valid` and `xfer_rdy` are both high. While `xfer_rdy` is low, `xfer_reg` and `xfer_addr` hold their values.
- R6: `done` is high for exactly one cycle, in the cycle after the last transfer is accepted. At that point `busy` and `xfer_valid` are low.
- R7: With `done`, `wb_en` equals instr bit 21. `wb_reg` is the base index, and `wb_val` is B+4n when ascending or B−4n when descending.
- R8: A taken start with an empty mask and `cond_pass` high gives, one cycle later, `done` and `err_empty` together, with no transfer and `wb_en` low.
- R9: A taken start with `cond_pass` low gives, one cycle later, `done` with no transfer, `wb_en` low and `err_empty` low.
- R10: `xfer_pc_store` is high exactly on store transfers of register 15. During such a transfer `pc_data` equals the instruction address plus 12.
- R11: After a synchronous reset, `busy`, `xfer_valid`, `done`, `wb_en` and `err_empty` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe for a new instruction |
| instr | input | 32 | Block transfer instruction word |
| base_val | input | 32 | Current value of the base register |
| instr_addr | input | 32 | Address of the instruction |
| cond_pass | input | 1 | Condition test result; low skips the instruction |
| xfer_rdy | input | 1 | Memory side accepts the presented transfer |
| busy | output | 1 | A transfer sequence is in progress |
| xfer_valid | output | 1 | A transfer is presented |
| xfer_reg | output | 4 | Register index of the presented transfer |
| xfer_addr | output | 32 | Word address of the presented transfer |
| xfer_load | output | 1 | 1 = load from memory, 0 = store |
| xfer_user | output | 1 | User-bank / status-load request |
| xfer_pc_store | output | 1 | Presented transfer stores register 15 |
| pc_data | output | 32 | Instruction address plus 12 |
| done | output | 1 | One-cycle end-of-instruction pulse |
| wb_en | output | 1 | Base write-back requested (with done) |
| wb_reg | output | 4 | Base register index for write-back |
| wb_val | output | 32 | Base write-back value |
| err_empty | output | 1 | Empty register mask reported (with done) |

## Verification
A corrupt remaining-mask register shows up on the ports at the next accepted transfer. The following `xfer_reg` skips or repeats an index, or `done` comes one transfer early or late. A wrong start address is visible on the very first presented transfer. It then persists as a constant offset on every later address, so a single-register case already exposes it. Write-back and empty-mask faults appear only in the `done` cycle, one cycle after the last acceptance, or one cycle after `start` for the skip and empty cases.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  localparam int NREG  = 16;
  localparam int REG_W = $clog2(NREG);
  localparam int CNT_W = $clog2(NREG) + 1;

  typedef struct packed {
    logic              is_blk;
    logic              pre;
    logic              up;
    logic              usr;
    logic              wb;
    logic              load;
    logic [REG_W-1:0]  rn;
    logic [NREG-1:0]   mask;
  } blk_fields_t;
endpackage

// File: rtl/blk_xfer_decode.sv
module blk_xfer_decode
  import blk_xfer_pkg::*;
(
  input  logic [31:0]      instr,
  output blk_fields_t      fld,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    fld.is_blk = (instr[27:25] == 3'b100);
    fld.pre    = instr[24];
    fld.up     = instr[23];
    fld.usr    = instr[22];
    fld.wb     = instr[21];
    fld.load   = instr[20];
    fld.rn     = instr[19:16];
    fld.mask   = instr[NREG-1:0];
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < NREG; i++)
      count = count + CNT_W'(instr[i]);
  end
endmodule

// File: rtl/blk_xfer_lowest.sv
module blk_xfer_lowest #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (vec[i]) idx = IW'(i);
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       instr,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] instr_addr,
  input  logic              cond_pass,
  input  logic              xfer_rdy,
  output logic              busy,
  output logic              xfer_valid,
  output logic [REG_W-1:0]  xfer_reg,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic              xfer_load,
  output logic              xfer_user,
  output logic              xfer_pc_store,
  output logic [ADDR_W-1:0] pc_data,
  output logic              done,
  output logic              wb_en,
  output logic [REG_W-1:0]  wb_reg,
  output logic [ADDR_W-1:0] wb_val,
  output logic              err_empty
);
  localparam logic [ADDR_W-1:0] WORD = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] PC_OFS = ADDR_W'(12);
  localparam logic [REG_W-1:0]  PC_IDX = REG_W'(NREG - 1);

  blk_fields_t      fld;
  logic [CNT_W-1:0] cnt;
  logic [NREG-1:0]  mask_rem, nxt_mask;
  logic [REG_W-1:0] first_idx, nxt_idx;
  logic [ADDR_W-1:0] span, start_addr, wb_calc;
  logic              wb_pend;

  blk_xfer_decode u_dec (.instr(instr), .fld(fld), .count(cnt));
  blk_xfer_lowest #(.N(NREG)) u_first (.vec(fld.mask), .idx(first_idx));
  blk_xfer_lowest #(.N(NREG)) u_next  (.vec(nxt_mask), .idx(nxt_idx));

  assign nxt_mask = mask_rem & (mask_rem - NREG'(1));
  assign span     = ADDR_W'(cnt) << 2;
  assign wb_calc  = fld.up ? base_val + span : base_val - span;

  always_comb begin
    unique case ({fld.pre, fld.up})
      2'b01:   start_addr = base_val;
      2'b11:   start_addr = base_val + WORD;
      2'b00:   start_addr = base_val - span + WORD;
      default: start_addr = base_val - span;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      xfer_valid <= 1'b0;
      xfer_reg   <= '0;
      xfer_addr  <= '0;
      xfer_load  <= 1'b0;
      xfer_user  <= 1'b0;
      pc_data    <= '0;
      done       <= 1'b0;
      wb_en      <= 1'b0;
      wb_reg     <= '0;
      wb_val     <= '0;
      err_empty  <= 1'b0;
      mask_rem   <= '0;
      wb_pend    <= 1'b0;
    end else begin
      done      <= 1'b0;
      wb_en     <= 1'b0;
      err_empty <= 1'b0;
      if (!busy) begin
        if (start && fld.is_blk) begin
          if (!cond_pass || fld.mask == '0) begin
            done      <= 1'b1;
            err_empty <= cond_pass;
          end else begin
            busy       <= 1'b1;
            xfer_valid <= 1'b1;
            mask_rem   <= fld.mask;
            xfer_reg   <= first_idx;
            xfer_addr  <= start_addr;
            xfer_load  <= fld.load;
            xfer_user  <= fld.usr;
            wb_pend    <= fld.wb;
            wb_reg     <= fld.rn;
            wb_val     <= wb_calc;
            pc_data    <= instr_addr + PC_OFS;
          end
        end
      end else if (xfer_valid && xfer_rdy) begin
        mask_rem <= nxt_mask;
        if (nxt_mask == '0) begin
          busy       <= 1'b0;
          xfer_valid <= 1'b0;
          done       <= 1'b1;
          wb_en      <= wb_pend;
        end else begin
          xfer_reg  <= nxt_idx;
          xfer_addr <= xfer_addr + WORD;
        end
      end
    end
  end

  assign xfer_pc_store = xfer_valid && !xfer_load && (xfer_reg == PC_IDX);

  // R2: indices strictly ascend across accepted transfers
  p_reg_ascend_r2: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && xfer_rdy) |=> (!xfer_valid || (xfer_reg > $past(xfer_reg))));
  // R3: next address is one word above the previous
  p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && xfer_rdy) |=> (!xfer_valid || (xfer_addr == $past(xfer_addr) + WORD)));
  // R5: stalled transfer holds
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !xfer_rdy) |=> (xfer_valid && $stable(xfer_reg) && $stable(xfer_addr)));
  // R6: done is a single-cycle pulse with sequencer idle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !xfer_valid));
  // R7: write-back strobe only alongside done
  p_wb_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> done);
  // R8: empty-mask report only alongside done, never with write-back
  p_empty_flag_r8: assert property (@(posedge clk) disable iff (rst)
    err_empty |-> (done && !wb_en));
endmodule

// File: tb/tb_blk_xfer_seq.sv
module tb_blk_xfer_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] base_val = '0;
  logic [31:0] instr_addr = 32'h0000_0800;
  logic        cond_pass = 1'b1;
  logic        xfer_rdy = 1'b0;
  logic        busy, xfer_valid, xfer_load, xfer_user, xfer_pc_store;
  logic [3:0]  xfer_reg, wb_reg;
  logic [31:0] xfer_addr, pc_data, wb_val;
  logic        done, wb_en, err_empty;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  blk_xfer_seq dut (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .base_val(base_val),
    .instr_addr(instr_addr), .cond_pass(cond_pass), .xfer_rdy(xfer_rdy),
    .busy(busy), .xfer_valid(xfer_valid), .xfer_reg(xfer_reg),
    .xfer_addr(xfer_addr), .xfer_load(xfer_load), .xfer_user(xfer_user),
    .xfer_pc_store(xfer_pc_store), .pc_data(pc_data), .done(done),
    .wb_en(wb_en), .wb_reg(wb_reg), .wb_val(wb_val), .err_empty(err_empty)
  );

  typedef struct packed {
    logic        p, u, s, w, l;
    logic [3:0]  rn;
    logic [15:0] mask;
    logic [31:0] base;
    logic [31:0] first;
    logic [31:0] wbv;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b0,1'b1,1'b0, 4'd2,  16'h0015, 32'h1000, 32'h1000, 32'h100C},
    '{1'b1,1'b1,1'b0,1'b0,1'b1, 4'd3,  16'h8001, 32'h1000, 32'h1004, 32'h1008},
    '{1'b0,1'b0,1'b1,1'b1,1'b1, 4'd13, 16'h00F0, 32'h1000, 32'h0FF4, 32'h0FF0},
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 4'd13, 16'hC00A, 32'h1000, 32'h0FF0, 32'h0FF0},
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 4'd5,  16'hFFFF, 32'h2000, 32'h2004, 32'h2040},
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 4'd7,  16'h8000, 32'h3000, 32'h3000, 32'h2FFC}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic p, u, s, w, l,
                                     input logic [3:0] rn, input logic [15:0] m);
    return {4'hE, 3'b100, p, u, s, w, l, rn, m};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic run_vec(input vec_t v, input int stall_phase);
    int k = 0;
    int last = -1;
    int nxt;
    bit fin = 0;
    @(negedge clk);
    instr = mk(v.p, v.u, v.s, v.w, v.l, v.rn, v.mask);
    base_val = v.base;
    cond_pass = 1'b1;
    start = 1'b1;
    for (int c = 0; c < 100 && !fin; c++) begin
      @(negedge clk);
      start = 1'b0;
      xfer_rdy = ((c + stall_phase) % 3) != 2;
      #1;
      if (xfer_valid && xfer_rdy) begin
        nxt = last + 1;
        while (nxt < 16 && !v.mask[nxt]) nxt++;
        chk(xfer_reg == 4'(nxt), "R2 register order", 32'(xfer_reg), 32'(nxt));
        chk(xfer_addr == v.first + 32'(4 * k), "R3 address", xfer_addr,
            v.first + 32'(4 * k));
        chk(xfer_load == v.l && xfer_user == v.s, "R4 direction/user",
            {30'b0, xfer_load, xfer_user}, {30'b0, v.l, v.s});
        chk(xfer_pc_store == (nxt == 15 && !v.l), "R10 pc store flag",
            32'(xfer_pc_store), 32'(nxt == 15 && !v.l));
        if (xfer_pc_store)
          chk(pc_data == 32'h0000_080C, "R10 pc data", pc_data, 32'h0000_080C);
        last = nxt;
        k++;
      end
      if (done) begin
        fin = 1;
        chk(k == $countones(v.mask), "R5/R6 transfer count", 32'(k),
            32'($countones(v.mask)));
        chk(!busy && !xfer_valid, "R6 idle at done", {30'b0, busy, xfer_valid}, 0);
        chk(wb_en == v.w, "R7 wb enable", 32'(wb_en), 32'(v.w));
        if (v.w)
          chk(wb_val == v.wbv && wb_reg == v.rn, "R7 wb value",
              wb_val, v.wbv);
      end
    end
    chk(fin, "R6 done seen", 32'(fin), 1);
    xfer_rdy = 1'b0;
    @(negedge clk); #1;
    chk(!done, "R6 done single cycle", 32'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R11 reset state
    chk(!busy && !xfer_valid && !done && !wb_en && !err_empty, "R11 reset",
        {27'b0, busy, xfer_valid, done, wb_en, err_empty}, 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // R8 empty mask
    @(negedge clk);
    instr = mk(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1, 16'h0000);
    start = 1'b1; cond_pass = 1'b1; xfer_rdy = 1'b1;
    @(negedge clk); start = 1'b0; #1;
    chk(done && err_empty && !wb_en && !xfer_valid, "R8 empty mask",
        {28'b0, done, err_empty, wb_en, xfer_valid}, 32'hC);

    // R9 condition fail
    @(negedge clk);
    instr = mk(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1, 16'h00FF);
    start = 1'b1; cond_pass = 1'b0;
    @(negedge clk); start = 1'b0; #1;
    chk(done && !err_empty && !wb_en && !xfer_valid, "R9 condition fail",
        {28'b0, done, err_empty, wb_en, xfer_valid}, 32'h8);
    @(negedge clk); #1;
    chk(!busy && !xfer_valid, "R9 no transfers", {30'b0, busy, xfer_valid}, 0);

    // R1 wrong opcode ignored
    cond_pass = 1'b1;
    instr = {4'hE, 3'b010, 25'h0A0_00FF};
    start = 1'b1;
    @(negedge clk); start = 1'b0; #1;
    chk(!busy && !done && !xfer_valid, "R1 opcode ignored",
        {29'b0, busy, done, xfer_valid}, 0);
    @(negedge clk); #1;
    chk(!done && !busy, "R1 opcode still idle", {30'b0, done, busy}, 0);

    // R1 start while busy ignored; R5 stall holds
    instr = mk(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 16'h0006);
    base_val = 32'h4000; xfer_rdy = 1'b0; start = 1'b1;
    @(negedge clk); #1;
    instr = mk(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 16'h0100);
    base_val = 32'h9000;
    @(negedge clk); start = 1'b0; #1;
    chk(xfer_valid && xfer_reg == 4'd1 && xfer_addr == 32'h4000,
        "R5 stall hold / R1 busy start ignored", xfer_addr, 32'h4000);
    xfer_rdy = 1'b1;
    @(negedge clk); #1;
    chk(xfer_reg == 4'd2 && xfer_addr == 32'h4004, "R2 second of busy case",
        xfer_addr, 32'h4004);
    @(negedge clk); #1;
    chk(done, "R6 done after two", 32'(done), 1);
    xfer_rdy = 1'b0;
    @(negedge clk); #1;
    chk(!busy && !done, "R1 second start not taken", {30'b0, busy, done}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule